// File: doc/BRIEF.md
# Dual-mode hash message scheduler

This block expands one 512-bit message block into the per-round word stream that a hash compression core consumes. It serves both SHA-256 and SM3. A block is loaded as sixteen 32-bit words into a sixteen-entry window. The compression core then takes one word per round through an advance handshake. Each advance shifts the window by one place. The oldest word leaves, and a freshly computed schedule word enters at the far end. The full expanded schedule is never stored.

In SHA-256 mode the block delivers W[0..63]. In SM3 mode it also generates W[64..67]. For each of the 64 rounds it presents the derived word W'[j] = W[j] ^ W[j+4] beside W[j]. The mode is captured when a block is loaded. When the last round word has been consumed, the block pulses `done` and returns to idle, ready for the next load.

Top module: `hash_msg_sched`

## Requirements
- R1: After reset, `busy`, `done` and `round_idx` are all zero.
- R2: A `load` while `busy` is low captures `blk_words` (word i in bits [32*i+31:32*i]). From the next cycle `busy` is high, `round_idx` is 0 and `word_out` equals word 0.
- R3: In SHA-256 mode (`mode_sel`=0), `word_out` during round t equals W[t], where W[t] = s1(W[t-2]) + W[t-7] + s0(W[t-15]) + W[t-16] mod 2^32 for t>=16. Here s0(x) = (x rotr 7)^(x rotr 18)^(x >> 3) and s1(x) = (x rotr 17)^(x rotr 19)^(x >> 10).
- R4: In SM3 mode (`mode_sel`=1), `word_out` during round j equals W[j], where W[j] = P1(W[j-16]^W[j-9]^(W[j-3] rotl 15)) ^ (W[j-13] rotl 7) ^ W[j-6] for j>=16, and P1(x) = x^(x rotl 15)^(x rotl 23).
- R5: While busy, `word_x` equals W[j]^W[j+4] in SM3 mode and zero in SHA-256 mode. This holds through round 63, which uses W[67].
- R6: While `adv` is low, the window, `word_out`, `word_x` and `round_idx` hold their values.
- R7: A `load` while `busy` is high is ignored. The words delivered and the round count are unchanged.
- R8: The advance taken in round 63 makes `done` high for exactly one cycle in the next cycle. In that cycle `busy` is low and `round_idx` is 0.
- R9: Each cycle with `busy` and `adv` both high increments `round_idx` by one, except in round 63.
- R10: The mode is taken from `mode_sel` at the accepted load. Changes of `mode_sel` while busy have no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | 0 = SHA-256, 1 = SM3; sampled at accepted load |
| load | input | 1 | Block load strobe, honoured only when idle |
| blk_words | input | 512 | Sixteen block words, word i at bits [32*i+31:32*i] |
| adv | input | 1 | Compression core consumed the current round word |
| busy | output | 1 | A block is being expanded; round outputs valid |
| word_out | output | 32 | Schedule word W for the current round |
| word_x | output | 32 | SM3 derived word W[j]^W[j+4]; zero in SHA-256 mode |
| round_idx | output | 6 | Current round index 0..63 |
| done | output | 1 | One-cycle pulse after the last round word is consumed |

## Verification
The hardest situation to reach from the ports is the tail of an SM3 block. There, `word_x` depends on W[64..67], which exist only in the window and never appear on `word_out`. At the same time, stray loads and mode flips arrive while the core is stalled on the final round. The stimulus runs blocks under random stall rates. It raises `load` and toggles `mode_sel` at random on busy cycles, including the final-round stall. Blocks are issued back to back so that a new load lands in the cycle right after `done`.

// File: rtl/hms_pkg.sv
// Package: shared word type, mode encoding and the bit-mixing functions of
// both hash schedules. Assumes 32-bit words throughout.
package hms_pkg;
    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        MODE_SHA = 1'b0,
        MODE_SM3 = 1'b1
    } hmode_e;

    // rotate left by a constant amount (1..31)
    function automatic word_t rotl(word_t x, int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    function automatic word_t rotr(word_t x, int unsigned n);
        return rotl(x, WORD_W - n);
    endfunction

    function automatic word_t sha_s0(word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t sha_s1(word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    function automatic word_t sm3_p1(word_t x);
        return x ^ rotl(x, 15) ^ rotl(x, 23);
    endfunction
endpackage

// File: rtl/hms_expand.sv
// Module: combinational next-word generator. Takes the window taps that
// the two recurrences need and returns the word that enters the far end
// of the window. Assumes the window holds W[t..t+15] with tap k = W[t+k].
module hms_expand
    import hms_pkg::*;
(
    input  hmode_e mode,
    input  word_t  tap0,
    input  word_t  tap1,
    input  word_t  tap3,
    input  word_t  tap7,
    input  word_t  tap9,
    input  word_t  tap10,
    input  word_t  tap13,
    input  word_t  tap14,
    output word_t  nxt
);
    word_t sha_w;
    word_t sm3_w;

    // both recurrences evaluated in parallel; the mode picks one
    always_comb begin
        sha_w = sha_s1(tap14) + tap9 + sha_s0(tap1) + tap0;
        sm3_w = sm3_p1(tap0 ^ tap7 ^ rotl(tap13, 15)) ^ rotl(tap3, 7) ^ tap10;
        nxt   = (mode == MODE_SM3) ? sm3_w : sha_w;
    end
endmodule

// File: rtl/hms_window.sv
// Module: the shifting word window. Loads a whole block in one cycle, then
// moves every entry one place toward entry 0 on each shift, with the new
// word entering at the top. Assumes load and shift never coincide.
module hms_window
    import hms_pkg::*;
#(
    parameter int WIN = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [WIN*WORD_W-1:0] blk,
    input  logic                shift,
    input  word_t               nxt,
    output word_t               win [WIN]
);
    for (genvar g = 0; g < WIN; g++) begin : g_ent
        if (g == WIN - 1) begin : g_top
            // top entry: takes the freshly generated word on a shift
            always_ff @(posedge clk) begin
                if (!rst_n)     win[g] <= '0;
                else if (load)  win[g] <= blk[g*WORD_W +: WORD_W];
                else if (shift) win[g] <= nxt;
            end
        end else begin : g_mid
            // other entries: take the neighbour above on a shift
            always_ff @(posedge clk) begin
                if (!rst_n)     win[g] <= '0;
                else if (load)  win[g] <= blk[g*WORD_W +: WORD_W];
                else if (shift) win[g] <= win[g+1];
            end
        end
    end
endmodule

// File: rtl/hms_ctrl.sv
// Module: round sequencer. Accepts a load only when idle, latches the mode,
// counts consumed rounds and pulses done after the last one. It also tells
// the window whether the word being generated lies inside the schedule.
module hms_ctrl
    import hms_pkg::*;
#(
    parameter int WIN       = 16,
    parameter int ROUNDS    = 64,
    parameter int SHA_WORDS = 64,
    parameter int SM3_WORDS = 68,
    localparam int RW       = $clog2(ROUNDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  hmode_e        mode_in,
    output logic          busy,
    output logic          done,
    output logic [RW-1:0] round,
    output hmode_e        mode,
    output logic          accept,
    output logic          shift,
    output logic          gen_en
);
    logic last;

    // handshake decode and schedule-length limit
    always_comb begin
        accept = load && !busy;
        shift  = busy && adv;
        last   = (int'(round) == ROUNDS - 1);
        gen_en = (WIN + int'(round)) < ((mode == MODE_SM3) ? SM3_WORDS : SHA_WORDS);
    end

    // busy flag, round counter, latched mode and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            round <= '0;
            mode  <= MODE_SHA;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy  <= 1'b1;
                round <= '0;
                mode  <= mode_in;
            end else if (shift) begin
                if (last) begin
                    busy  <= 1'b0;
                    round <= '0;
                    done  <= 1'b1;
                end else begin
                    round <= round + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hash_msg_sched.sv
// Module: top of the dual-mode message scheduler. Ties the sequencer, the
// window and the next-word generator together, and drives the round word
// from entry 0 and the SM3 derived word from entries 0 and 4.
// Assumes WIN >= 16 so that every recurrence tap exists.
module hash_msg_sched
    import hms_pkg::*;
#(
    parameter int WIN       = 16,
    parameter int ROUNDS    = 64,
    parameter int SHA_WORDS = 64,
    parameter int SM3_WORDS = 68,
    localparam int RW       = $clog2(ROUNDS),
    localparam int BLK_W    = WIN * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              load,
    input  logic [BLK_W-1:0]  blk_words,
    input  logic              adv,
    output logic              busy,
    output logic [WORD_W-1:0] word_out,
    output logic [WORD_W-1:0] word_x,
    output logic [RW-1:0]     round_idx,
    output logic              done
);
    hmode_e mode_q;
    hmode_e mode_in;
    logic   accept;
    logic   shift;
    logic   gen_en;
    word_t  nxt_raw;
    word_t  nxt;
    word_t  win [WIN];

    assign mode_in = hmode_e'(mode_sel);

    hms_ctrl #(
        .WIN(WIN), .ROUNDS(ROUNDS), .SHA_WORDS(SHA_WORDS), .SM3_WORDS(SM3_WORDS)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .mode_in(mode_in),
        .busy(busy), .done(done), .round(round_idx), .mode(mode_q),
        .accept(accept), .shift(shift), .gen_en(gen_en)
    );

    hms_expand u_expand (
        .mode(mode_q),
        .tap0(win[0]), .tap1(win[1]), .tap3(win[3]), .tap7(win[7]),
        .tap9(win[9]), .tap10(win[10]), .tap13(win[13]), .tap14(win[14]),
        .nxt(nxt_raw)
    );

    // words past the schedule length enter as zero
    always_comb nxt = gen_en ? nxt_raw : '0;

    hms_window #(.WIN(WIN)) u_window (
        .clk(clk), .rst_n(rst_n), .load(accept), .blk(blk_words),
        .shift(shift), .nxt(nxt), .win(win)
    );

    // round outputs: fixed taps of the window
    always_comb begin
        word_out = win[0];
        word_x   = (busy && mode_q == MODE_SM3) ? (win[0] ^ win[4]) : '0;
    end
endmodule

// File: rtl/hms_sched_checker.sv
// Module: protocol checker for the scheduler, bound to the top. Watches the
// handshake, the round count and the done pulse at the ports only.
module hms_sched_checker #(
    parameter int ROUNDS = 64,
    localparam int RW    = $clog2(ROUNDS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load,
    input logic          adv,
    input logic          busy,
    input logic          done,
    input logic [RW-1:0] round_idx,
    input logic [31:0]   word_out
);
    assert_load_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && load) |=> (busy && round_idx == '0));

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !adv) |=> (busy && $stable(word_out) && $stable(round_idx)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && round_idx == '0));

    assert_last_round_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && adv && int'(round_idx) == ROUNDS - 1) |=> done);

    assert_round_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && adv && int'(round_idx) != ROUNDS - 1)
        |=> (busy && round_idx == $past(round_idx) + 1'b1));
endmodule

bind hash_msg_sched hms_sched_checker #(.ROUNDS(ROUNDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .busy(busy),
    .done(done), .round_idx(round_idx), .word_out(word_out)
);

// File: tb/hash_msg_sched_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model (full schedule array per block, round
// and busy counters), compared against the ports on every falling edge.
module hash_msg_sched_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         mode_sel;
    logic         load;
    logic [511:0] blk_words;
    logic         adv;
    logic         busy;
    logic [31:0]  word_out;
    logic [31:0]  word_x;
    logic [5:0]   round_idx;
    logic         done;

    int errs   = 0;
    int checks = 0;
    bit wd_hit = 0;

    bit          m_busy, m_done, m_mode;
    int          m_round;
    logic [31:0] ew [68];

    always #10 clk = ~clk;

    hash_msg_sched u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .load(load),
        .blk_words(blk_words), .adv(adv), .busy(busy), .word_out(word_out),
        .word_x(word_x), .round_idx(round_idx), .done(done)
    );

    function automatic logic [31:0] rl(logic [31:0] x, int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h (round %0d)", tag, act, exp, m_round);
        end
    endtask

    // expected schedule from the recurrences stated in R3 and R4
    task automatic build(logic [511:0] b, bit sm3);
        for (int i = 0; i < 16; i++) ew[i] = b[i*32 +: 32];
        for (int t = 16; t < 68; t++) begin
            if (sm3) begin
                logic [31:0] a;
                a = ew[t-16] ^ ew[t-9] ^ rl(ew[t-3], 15);
                ew[t] = (a ^ rl(a, 15) ^ rl(a, 23)) ^ rl(ew[t-13], 7) ^ ew[t-6];
            end else if (t < 64) begin
                ew[t] = (rl(ew[t-2], 15) ^ rl(ew[t-2], 13) ^ (ew[t-2] >> 10)) + ew[t-7]
                      + (rl(ew[t-15], 25) ^ rl(ew[t-15], 14) ^ (ew[t-15] >> 3)) + ew[t-16];
            end else begin
                ew[t] = '0;
            end
        end
    endtask

    // reference model state update at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_round = 0; m_mode = 0;
        end else begin
            m_done = 0;
            if (!m_busy && load) begin
                build(blk_words, mode_sel);
                m_busy = 1; m_round = 0; m_mode = mode_sel;   // R10: mode latched here
            end else if (m_busy && adv) begin
                if (m_round == 63) begin
                    m_busy = 0; m_round = 0; m_done = 1;
                end else begin
                    m_round++;
                end
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !wd_hit) begin
            chk("R2 busy", {31'b0, busy}, {31'b0, m_busy});
            chk("R8 done", {31'b0, done}, {31'b0, m_done});
            chk("R9 round_idx", {26'b0, round_idx}, m_round[31:0]);
            if (m_busy) begin
                chk(m_mode ? "R4 word_out" : "R3 word_out", word_out, ew[m_round]);
                chk("R5 word_x", word_x, m_mode ? (ew[m_round] ^ ew[m_round+4]) : 32'h0);
            end
        end
    end

    // one block: stall_pct percent of busy cycles without adv (R6);
    // poke raises load and flips mode_sel while busy (R7, R10)
    task automatic run_block(bit m, int stall_pct, bit poke, bit anchor);
        logic [511:0] b;
        if (anchor) begin
            b = '0;
            b[31:0]    = 32'h61626380;
            b[511:480] = 32'h00000018;
        end else begin
            for (int i = 0; i < 16; i++) b[i*32 +: 32] = $urandom;
        end
        blk_words = b; mode_sel = m; load = 1'b1; adv = 1'b0;
        @(negedge clk);
        load = 1'b0;
        while (m_busy) begin
            adv = ($urandom % 100) >= stall_pct;
            if (poke) begin
                load     = ($urandom % 3) == 0;
                mode_sel = $urandom % 2;
                for (int i = 0; i < 16; i++) blk_words[i*32 +: 32] = $urandom;
            end
            @(negedge clk);
            // R3 fixed anchor values for a one-word padded message block
            if (anchor && m_busy && m_round == 16) chk("R3 anchor W16", word_out, 32'h61626380);
            if (anchor && m_busy && m_round == 17) chk("R3 anchor W17", word_out, 32'h000f0000);
        end
        load = 1'b0; adv = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; load = 1'b0; adv = 1'b0; mode_sel = 1'b0; blk_words = '0;
        repeat (3) @(negedge clk);
        chk("R1 busy", {31'b0, busy}, 32'h0);
        chk("R1 done", {31'b0, done}, 32'h0);
        chk("R1 round_idx", {26'b0, round_idx}, 32'h0);
        rst_n = 1'b1;
        adv = 1'b1;                  // advance while idle: no effect expected
        repeat (2) @(negedge clk);
        adv = 1'b0;
        run_block(1'b0, 0, 1'b0, 1'b1);
        run_block(1'b1, 0, 1'b0, 1'b0);
        run_block(1'b0, 40, 1'b1, 1'b0);
        run_block(1'b1, 40, 1'b1, 1'b0);
        run_block(1'b1, 75, 1'b1, 1'b0);
        run_block(1'b0, 10, 1'b1, 1'b0);
        run_block(1'b1, 90, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        wd_hit = 1;
        errs++; checks++;
        $display("FAIL R8: watchdog expired, done actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule